// File: doc/BRIEF.md
# Indirect Programmed-I/O Memory Port

This block lets a host reach two on-chip memories that are not in its address map: a 128-dword descriptor memory and a 1024-dword data memory. The host first writes one access word to a start register. That word chooses the memory, the starting dword offset and the direction of the transfer. The host then polls a ready bit. After that it moves dwords one at a time through a single data-port register. The memory address steps forward by one dword after every transfer.

In read mode the port fetches the addressed dword ahead of time, so the first read of the data port already returns valid data. Each later read fetches the next dword. In write mode each write to the data port is sent to memory at the current address. The direction stored in the access word always decides what a data-port access does. The two memories are synchronous single-port RAMs with one cycle of read latency, and they sit outside this block.

Top module: `pio_mem_port`

## Requirements
- R1: After reset the ready register (byte offset 044h) reads 0, the start register (byte offset 0A4h) reads 0, and neither memory is enabled.
- R2: Access-word encoding: bit 15 chooses the memory (0 = descriptor, 1 = data) and bit 14 gives the direction (1 = write, 0 = read). The dword offset is taken from bits 6:0 for the descriptor memory and from bits 9:0 for the data memory. Reading the start register returns bit 15, bit 14 and the current offset in bits 9:0, with every other bit 0. The data port is at byte offset 02Ch. Any other offset reads 0.
- R3: A read-mode access word holds ready bit 0 high for exactly two cycles. The first data-port read after that returns the dword at the offset given.
- R4: In read mode each data-port read returns the next consecutive dword and holds ready high for the next two cycles.
- R5: In write mode each data-port write stores its data at the current offset of the selected memory, holds ready high for one cycle, and then advances the offset by one.
- R6: The offset wraps from 127 to 0 in the descriptor memory and from 1023 to 0 in the data memory.
- R7: The direction in the access word takes precedence. In read mode, a data-port write is handled as a read: it consumes the dword and performs no memory write. In write mode, a data-port read returns 0 and changes neither memory nor the offset.
- R8: A data-port access made while ready is high returns 0 and is ignored.
- R9: A new access word is accepted at any time and replaces any fetch still pending.
- R10: Only the memory selected by the access word is ever enabled, and writes reach a memory only in write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| desc_en | output | 1 | Descriptor memory enable |
| desc_we | output | 1 | Descriptor memory write enable |
| desc_addr | output | 7 | Descriptor memory dword address |
| desc_wdata | output | 32 | Descriptor memory write data |
| desc_rdata | input | 32 | Descriptor memory read data, one cycle after enable |
| dmem_en | output | 1 | Data memory enable |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 10 | Data memory dword address |
| dmem_wdata | output | 32 | Data memory write data |
| dmem_rdata | input | 32 | Data memory read data, one cycle after enable |

## Verification
Two kinds of fault inside the block show up at different times. A corrupted pointer or segment flag shows up at once in the start-register readback, and one transfer later as a wrong dword or a write at a wrong memory address. A wrong busy state shows up within a cycle in the ready bit, or as a memory strobe in a cycle where none is expected. Each clock the memory write strobes are compared with a behavioural model, so a commit that is misplaced or spurious is caught in the cycle it happens. A fetch error is caught at the next data-port read.

// File: rtl/pio_mem_port.sv
module pio_mem_port #(
  parameter int DESC_AW = 7,
  parameter int DATA_AW = 10,
  parameter int RA_W    = 9,
  parameter logic [RA_W-1:0] A_START = 9'h0A4,
  parameter logic [RA_W-1:0] A_DATA  = 9'h02C,
  parameter logic [RA_W-1:0] A_READY = 9'h044
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [RA_W-1:0]    reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               desc_en,
  output logic               desc_we,
  output logic [DESC_AW-1:0] desc_addr,
  output logic [31:0]        desc_wdata,
  input  logic [31:0]        desc_rdata,
  output logic               dmem_en,
  output logic               dmem_we,
  output logic [DATA_AW-1:0] dmem_addr,
  output logic [31:0]        dmem_wdata,
  input  logic [31:0]        dmem_rdata
);
  localparam int PTR_W = DATA_AW;
  localparam logic [PTR_W-1:0] DESC_MASK = PTR_W'((1 << DESC_AW) - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CAPT, S_COMMIT} st_t;

  st_t              st;
  logic             seg, dir_wr;
  logic [PTR_W-1:0] ptr;
  logic [31:0]      dbuf, wbuf;

  function automatic logic [PTR_W-1:0] wrapd(input logic s, input logic [PTR_W-1:0] p);
    return s ? p : (p & DESC_MASK);
  endfunction

  wire aw_wr   = reg_wr && reg_addr == A_START;
  wire dp_hit  = reg_addr == A_DATA;
  wire idle    = st == S_IDLE;
  wire busy    = !idle;
  wire consume = idle && !dir_wr && dp_hit && (reg_rd || reg_wr);
  wire commit  = idle && dir_wr && dp_hit && reg_wr;
  wire mem_go  = st == S_FETCH || st == S_COMMIT;
  wire mem_wr  = st == S_COMMIT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      seg    <= 1'b0;
      dir_wr <= 1'b0;
      ptr    <= '0;
      dbuf   <= '0;
      wbuf   <= '0;
    end else if (aw_wr) begin
      seg    <= reg_wdata[15];
      dir_wr <= reg_wdata[14];
      ptr    <= wrapd(reg_wdata[15], reg_wdata[PTR_W-1:0]);
      st     <= reg_wdata[14] ? S_IDLE : S_FETCH;
    end else begin
      case (st)
        S_IDLE: begin
          if (commit) begin
            wbuf <= reg_wdata;
            st   <= S_COMMIT;
          end else if (consume) begin
            st <= S_FETCH;
          end
        end
        S_FETCH: st <= S_CAPT;
        S_CAPT: begin
          dbuf <= seg ? dmem_rdata : desc_rdata;
          ptr  <= wrapd(seg, ptr + 1'b1);
          st   <= S_IDLE;
        end
        default: begin
          ptr <= wrapd(seg, ptr + 1'b1);
          st  <= S_IDLE;
        end
      endcase
    end
  end

  assign desc_en    = mem_go && !seg;
  assign desc_we    = mem_wr && !seg;
  assign desc_addr  = ptr[DESC_AW-1:0];
  assign desc_wdata = wbuf;
  assign dmem_en    = mem_go && seg;
  assign dmem_we    = mem_wr && seg;
  assign dmem_addr  = ptr;
  assign dmem_wdata = wbuf;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_START)
      reg_rdata = {16'b0, seg, dir_wr, {(14 - PTR_W){1'b0}}, ptr};
    else if (reg_addr == A_READY)
      reg_rdata = {31'b0, busy};
    else if (reg_addr == A_DATA && idle && !dir_wr)
      reg_rdata = dbuf;
  end
endmodule

// File: rtl/pio_mem_port_chk.sv
module pio_mem_port_chk #(
  parameter int RA_W  = 9,
  parameter int PTR_W = 10,
  parameter logic [RA_W-1:0] A_START = 9'h0A4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [RA_W-1:0]  reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             desc_en,
  input logic             desc_we,
  input logic             dmem_en,
  input logic             dmem_we,
  input logic             busy,
  input logic             dir_wr,
  input logic [PTR_W-1:0] ptr
);
  p_one_mem_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_en && dmem_en));

  p_write_needs_wmode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_we || dmem_we) |-> dir_wr);

  p_mem_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_en || dmem_en) |-> busy);

  p_prefetch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_START && !reg_wdata[14]) |=> busy);

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !reg_wr && !reg_rd) |=> $stable(ptr));

  p_commit_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((desc_we || dmem_we) && !(reg_wr && reg_addr == A_START)) |=> !busy);
endmodule

bind pio_mem_port pio_mem_port_chk #(.RA_W(RA_W), .PTR_W(DATA_AW), .A_START(A_START)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .desc_en(desc_en), .desc_we(desc_we), .dmem_en(dmem_en),
  .dmem_we(dmem_we), .busy(busy), .dir_wr(dir_wr), .ptr(ptr)
);

// File: tb/pio_mem_port_bench.sv
module pio_mem_port_bench;
  localparam int CLK_P = 10;
  localparam logic [8:0] A_START = 9'h0A4, A_DATA = 9'h02C, A_READY = 9'h044;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [8:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic desc_en, desc_we, dmem_en, dmem_we;
  logic [6:0]  desc_addr;
  logic [9:0]  dmem_addr;
  logic [31:0] desc_wdata, dmem_wdata, desc_q, dmem_q;

  always #(CLK_P/2) clk = ~clk;

  pio_mem_port u_pio_mem_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .desc_en(desc_en), .desc_we(desc_we), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
    .desc_rdata(desc_q), .dmem_en(dmem_en), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_q));

  logic [31:0] ram_d [128];
  logic [31:0] ram_m [1024];
  logic [31:0] mdl_d [128];
  logic [31:0] mdl_m [1024];

  always @(posedge clk) begin
    if (desc_en) begin
      if (desc_we) ram_d[desc_addr] <= desc_wdata;
      desc_q <= ram_d[desc_addr];
    end
    if (dmem_en) begin
      if (dmem_we) ram_m[dmem_addr] <= dmem_wdata;
      dmem_q <= ram_m[dmem_addr];
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_ptr, m_waddr;
  bit m_seg, m_dir, m_fetch, m_wpend, m_wseg;
  logic [31:0] m_buf, m_wdat;

  function automatic int msize(input bit s);
    return s ? 1024 : 128;
  endfunction

  task automatic mdl_write(input bit s, input int a, input logic [31:0] v);
    if (s) mdl_m[a] = v; else mdl_d[a] = v;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ptr = 0; m_seg = 0; m_dir = 0; m_fetch = 0; m_wpend = 0; m_buf = 0;
    end else if (reg_wr && reg_addr == A_START) begin
      if (m_wpend && m_cnt == 1) mdl_write(m_wseg, m_waddr, m_wdat);
      m_seg = reg_wdata[15];
      m_dir = reg_wdata[14];
      m_ptr = int'(reg_wdata[11:0]) % msize(m_seg);
      m_cnt = m_dir ? 0 : 2;
      m_fetch = !m_dir;
      m_wpend = 0;
    end else if (m_cnt != 0) begin
      m_cnt--;
      if (m_cnt == 0) begin
        if (m_fetch) m_buf = m_seg ? mdl_m[m_ptr] : mdl_d[m_ptr];
        else mdl_write(m_wseg, m_waddr, m_wdat);
        m_ptr = (m_ptr + 1) % msize(m_seg);
        m_wpend = 0;
      end
    end else if (reg_addr == A_DATA && (reg_wr || reg_rd)) begin
      if (!m_dir) begin
        m_cnt = 2; m_fetch = 1;
      end else if (reg_wr) begin
        m_cnt = 1; m_fetch = 0; m_wpend = 1;
        m_waddr = m_ptr; m_wseg = m_seg; m_wdat = reg_wdata;
      end
    end
  end

  // per-clock comparison of the memory strobes against the model
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1 mem idle in reset", {30'b0, desc_en, dmem_en}, 32'b0);
    end else if (desc_we || dmem_we || (m_wpend && m_cnt == 1)) begin
      chk("R5 write strobe", {31'b0, desc_we || dmem_we}, 32'd1);
      chk("R10 write target", {31'b0, dmem_we}, {31'b0, m_wseg});
      chk("R5 write addr", dmem_we ? 32'(dmem_addr) : 32'(desc_addr), 32'(m_waddr));
      chk("R5 write data", dmem_we ? dmem_wdata : desc_wdata, m_wdat);
    end else if (desc_en || dmem_en) begin
      chk("R10 fetch target", {31'b0, dmem_en}, {31'b0, m_seg});
    end
  end

  function automatic logic [31:0] exp_rd(input logic [8:0] a);
    if (a == A_START) return {16'b0, m_seg, m_dir, 4'b0, 10'(m_ptr)};
    if (a == A_READY) return {31'b0, m_cnt != 0};
    if (a == A_DATA)  return (m_cnt == 0 && !m_dir) ? m_buf : 32'b0;
    return 32'b0;
  endfunction

  task automatic op(input string tag, input bit wr, input bit rd, input logic [8:0] a,
                    input logic [31:0] wd, output logic [31:0] got);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    #1 got = reg_rdata;
    if (rd) chk(tag, got, exp_rd(a));
    @(posedge clk);
    #1 reg_wr = 0; reg_rd = 0;
  endtask

  task automatic poll(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      op(tag, 0, 1, A_READY, 0, v);
      if (v == 0) break;
    end
  endtask

  logic [31:0] v;
  bit done = 0;

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      ram_d[i] = 32'hC0DE_0000 + i; mdl_d[i] = 32'hC0DE_0000 + i;
    end
    for (int i = 0; i < 1024; i++) begin
      ram_m[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
      mdl_m[i] = 32'h5A00_0000 ^ (i * 32'h0001_0203);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    op("R1 ready after reset", 0, 1, A_READY, 0, v);
    op("R1 start after reset", 0, 1, A_START, 0, v);
    chk("R1 start is zero", v, 0);
    // R2 encoding and readback
    op("R2 aw", 1, 0, A_START, 32'h0000_0005, v);
    op("R2 readback desc", 0, 1, A_START, 0, v);
    chk("R2 desc word", v, 32'h0000_0005);
    op("R2 aw data write", 1, 0, A_START, 32'h0000_C3FE, v);
    op("R2 readback data", 0, 1, A_START, 0, v);
    chk("R2 data word", v, 32'h0000_C3FE);
    op("R2 unmapped", 0, 1, 9'h100, 0, v);
    // R3 prefetch
    op("R3 aw", 1, 0, A_START, 32'h0000_000A, v);
    op("R3 busy 1", 0, 1, A_READY, 0, v);
    chk("R3 busy first", v, 1);
    op("R3 busy 2", 0, 1, A_READY, 0, v);
    op("R3 ready", 0, 1, A_READY, 0, v);
    chk("R3 ready low", v, 0);
    op("R3 first dword", 0, 1, A_DATA, 0, v);
    chk("R3 value", v, 32'hC0DE_000A);
    // R4 consecutive reads
    for (int k = 0; k < 5; k++) begin
      poll("R4 poll");
      op("R4 next dword", 0, 1, A_DATA, 0, v);
    end
    // R5 writes into data memory
    op("R5 aw", 1, 0, A_START, 32'h0000_C064, v);
    for (int k = 0; k < 4; k++) begin
      op("R5 write", 1, 0, A_DATA, 32'hBEEF_0000 + k, v);
      op("R5 busy", 0, 1, A_READY, 0, v);
      poll("R5 poll");
    end
    op("R5 ptr advanced", 0, 1, A_START, 0, v);
    op("R5 aw back", 1, 0, A_START, 32'h0000_8064, v);
    for (int k = 0; k < 4; k++) begin
      poll("R5 poll rd");
      op("R5 readback", 0, 1, A_DATA, 0, v);
      chk("R5 stored", v, 32'hBEEF_0000 + k);
    end
    // R6 wrap
    op("R6 aw desc", 1, 0, A_START, 32'h0000_007E, v);
    for (int k = 0; k < 3; k++) begin
      poll("R6 poll");
      op("R6 desc wrap read", 0, 1, A_DATA, 0, v);
    end
    op("R6 aw data", 1, 0, A_START, 32'h0000_C3FE, v);
    for (int k = 0; k < 3; k++) begin
      op("R6 data wrap write", 1, 0, A_DATA, 32'h7000_0000 + k, v);
      poll("R6 poll w");
    end
    op("R6 ptr wrapped", 0, 1, A_START, 0, v);
    chk("R6 wrapped word", v, 32'h0000_C001);
    op("R6 aw data rd", 1, 0, A_START, 32'h0000_83FF, v);
    for (int k = 0; k < 2; k++) begin
      poll("R6 poll r");
      op("R6 data wrap read", 0, 1, A_DATA, 0, v);
    end
    chk("R6 wrapped value", v, 32'h7000_0002);
    // R7 direction override
    op("R7 aw", 1, 0, A_START, 32'h0000_0014, v);
    poll("R7 poll");
    op("R7 write as read", 1, 0, A_DATA, 32'hDEAD_DEAD, v);
    poll("R7 poll 2");
    op("R7 next read", 0, 1, A_DATA, 0, v);
    chk("R7 skipped one", v, 32'hC0DE_0015);
    op("R7 aw wmode", 1, 0, A_START, 32'h0000_C0C8, v);
    op("R7 read in wmode", 0, 1, A_DATA, 0, v);
    chk("R7 zero", v, 0);
    op("R7 ptr unchanged", 0, 1, A_START, 0, v);
    chk("R7 word", v, 32'h0000_C0C8);
    // R8 busy accesses ignored
    op("R8 aw", 1, 0, A_START, 32'h0000_401E, v);
    op("R8 write A", 1, 0, A_DATA, 32'h1111_1111, v);
    op("R8 write while busy", 1, 0, A_DATA, 32'h2222_2222, v);
    poll("R8 poll");
    op("R8 ptr", 0, 1, A_START, 0, v);
    chk("R8 one advance", v, 32'h0000_401F);
    op("R8 aw rd", 1, 0, A_START, 32'h0000_001E, v);
    op("R8 read while busy", 0, 1, A_DATA, 0, v);
    chk("R8 busy read zero", v, 0);
    poll("R8 poll rd");
    op("R8 A stored", 0, 1, A_DATA, 0, v);
    chk("R8 A value", v, 32'h1111_1111);
    poll("R8 poll rd2");
    op("R8 next untouched", 0, 1, A_DATA, 0, v);
    chk("R8 original", v, 32'hC0DE_001F);
    // R9 replacement of a pending fetch
    op("R9 aw first", 1, 0, A_START, 32'h0000_0032, v);
    op("R9 aw second", 1, 0, A_START, 32'h0000_803C, v);
    poll("R9 poll");
    op("R9 value", 0, 1, A_DATA, 0, v);
    chk("R9 from data mem", v, 32'h5A00_0000 ^ (60 * 32'h0001_0203));
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule